// File: doc/BRIEF.md
# Card Controller Register and Interrupt Front End

This block is the software-visible face of a memory-card host controller. A simple synchronous bus port reaches a bank of configuration registers (supply control, bus clock control, command argument, data timer, transfer length, data control), two interrupt mask registers, a composite status register with write-one-to-clear event bits, a 16-word aliased window onto the data FIFO, and a fixed block of identification bytes. Two interrupt outputs each go high when any status bit enabled by that line's own mask is set.

Behind the registers sit a small data engine and a command unit. The data engine moves bytes between a word FIFO and a card-side stub, packing four bytes per word in little-endian order. The command unit answers commands from a stub card. The front end adds one flow-control rule: after software pops a word through the FIFO window, the engine stops moving data until software polls the status or FIFO-count register. That poll returns the value captured before the engine resumes.

Bus reads return data one cycle after the access, from a register. Both interrupt lines are registered, so each follows its status and mask one cycle later.

Top module: `mmc_host_regs`

## Requirements
- R1: After synchronous reset, every register (supply, clock, argument, command, response, timer, length, data control, data count, status, both masks) reads 0, the hold flag is clear and both interrupt lines are low.
- R2: Supply (0x00), clock (0x04) and data control (0x2C) keep bits 7:0 only; length (0x28) keeps bits 15:0; argument (0x08), timer (0x24) and the masks (0x3C, 0x40) keep all 32 bits. Data control bit 0 reads back as the engine-busy flag.
- R3: Word reads at 0xFE0, 0xFE4 … 0xFFC return the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that address order.
- R4: Reads of offsets with no register return 0, and writes to them change no register.
- R5: A write to 0x38 clears the status bits 10:0 whose written bit is 1. The event bits are 2 command timeout, 6 response received, 7 command sent, 8 data end and 10 block end. Writes to 0x38 do not affect the FIFO bits 21:12.
- R6: Interrupt line i (0 uses mask 0x3C, 1 uses mask 0x40) is high one cycle after (status AND mask i) becomes nonzero, and low one cycle after it becomes zero.
- R7: A write to 0x0C with bit 10 set and bit 9 clear issues command index bits 5:0. Bit 6 requests a response and bit 7 a four-word one. The register keeps the written value with bit 10 cleared. Index 0x3F times out (bit 2). A short response sets 0x14 to the argument and 0x18..0x20 to 0. A long one sets 0x14 = argument, 0x18 = ~argument, 0x1C = argument and 0x20 = ~argument with bit 0 cleared. A response sets bit 6 and writes the index to 0x10. No response requested sets bit 7. Bit 9 set issues nothing.
- R8: Writing data control with bit 0 set loads the byte count from the length register. With bit 1 = 1 the stub card supplies byte k of the transfer with value k mod 256, packed little-endian four per word, and the last partial word is zero-padded. When the count reaches 0, status bits 8 and 10 are set; once the FIFO is also empty, data control bit 0 reads 0.
- R9: While the byte count is nonzero or the FIFO holds data, status shows the FIFO state. Card-to-host uses 13 active, 15 level at least half, 17 full, 19 empty and 21 not empty. Host-to-card uses 12 active, 14 level at most half, 16 full, 18 empty and 20 not empty. Otherwise all of these bits are 0.
- R10: 0x30 reads the remaining byte count, and 0x48 reads (count + 3) >> 2.
- R11: A read of the FIFO window (0x80..0xBC) that finds data pops one word and sets a hold flag that stops the data engine. A read of 0x34 or 0x48 clears the flag and returns the value from before the engine resumes.
- R12: A FIFO window read with the FIFO empty returns 0 and pops nothing. A FIFO window write while the byte count is 0 is ignored.
- R13: With data control bit 1 = 0, each word written to the FIFO window is consumed by the engine, which lowers the byte count by 4 (or by what remains).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| irq_out | output | 2 | Interrupt lines, one per mask |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and the default 16-bit length. With that depth, a 22-byte card-to-host transfer fills the FIFO within a few cycles. The full, half and not-empty indications are then visible in every state, and the hold flag can be seen keeping the FIFO at three words after a pop. The transfer also ends on a two-byte partial word, which shows the zero padding and the rounding of the FIFO count.

// File: rtl/mmc_regs_pkg.sv
package mmc_regs_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;
  localparam int NUM_IRQ = 2;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_SUPPLY  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CLKCTL  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_ARG     = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CMD     = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RSPIDX  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RSP0    = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_RSP1    = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_RSP2    = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_RSP3    = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_TIMER   = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_LEN     = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_DCTL    = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_DCNT    = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_CLR     = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_MASK0   = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_MASK1   = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_WCNT    = 12'h048;

  // command word fields
  localparam int CMD_IDX_W = 6;
  localparam int CMD_RESP  = 6;
  localparam int CMD_LONG  = 7;
  localparam int CMD_HOLD  = 9;
  localparam int CMD_GO    = 10;

  // data control fields
  localparam int DC_RUN = 0;
  localparam int DC_RX  = 1;

  // status bit positions
  localparam int ST_CMD_TMO   = 2;
  localparam int ST_RSP_DONE  = 6;
  localparam int ST_CMD_DONE  = 7;
  localparam int ST_DAT_END   = 8;
  localparam int ST_BLK_END   = 10;
  localparam int ST_TX_ACT    = 12;
  localparam int ST_RX_ACT    = 13;
  localparam int ST_TX_HALF   = 14;
  localparam int ST_RX_HALF   = 15;
  localparam int ST_TX_FULL   = 16;
  localparam int ST_RX_FULL   = 17;
  localparam int ST_TX_EMPTY  = 18;
  localparam int ST_RX_EMPTY  = 19;
  localparam int ST_TX_AVAIL  = 20;
  localparam int ST_RX_AVAIL  = 21;
  localparam int EVT_W        = 11;

  localparam logic [CMD_IDX_W-1:0] NO_CARD_IDX = 6'h3F;

  function automatic logic [7:0] ident_byte(input logic [2:0] k);
    case (k)
      3'd0: return 8'h81;
      3'd1: return 8'h11;
      3'd2: return 8'h04;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/mmc_word_fifo.sv
module mmc_word_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [PTR_W:0]   level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (level == (PTR_W+1)'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/mmc_data_engine.sv
module mmc_data_engine #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int W = mmc_regs_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_rx,
  input  logic [LEN_W-1:0] len,
  input  logic             hold,
  input  logic             bus_push,
  input  logic [W-1:0]     bus_push_data,
  input  logic             bus_pop,
  output logic [W-1:0]     head,
  output logic [PTR_W:0]   level,
  output logic             full,
  output logic             empty,
  output logic [LEN_W-1:0] count,
  output logic             active,
  output logic             done
);
  logic             dir_rx;
  logic [LEN_W-1:0] len_q, sent;
  logic [2:0]       take;
  logic             go, eng_push, eng_pop;
  logic [W-1:0]     rx_word;

  assign go       = active && !hold && !bus_push && !bus_pop && (count != '0);
  assign eng_push = go && dir_rx && !full;
  assign eng_pop  = go && !dir_rx && !empty;
  assign take     = (count >= LEN_W'(4)) ? 3'd4 : count[2:0];
  assign sent     = len_q - count;
  assign done     = active && (count == '0);

  // stub card: byte k of a transfer carries k mod 256
  always_comb begin
    rx_word = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(take)) rx_word[i*8 +: 8] = sent[7:0] + 8'(i);
    end
  end

  mmc_word_fifo #(.DEPTH(DEPTH), .WIDTH(W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (bus_push || eng_push),
    .push_data (bus_push ? bus_push_data : rx_word),
    .pop       (bus_pop || eng_pop),
    .head      (head),
    .level     (level),
    .full      (full),
    .empty     (empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      len_q  <= '0;
      dir_rx <= 1'b0;
      active <= 1'b0;
    end else if (start) begin
      count  <= len;
      len_q  <= len;
      dir_rx <= start_rx;
      active <= 1'b1;
    end else begin
      if (eng_push || eng_pop) count <= count - LEN_W'(take);
      if (active && (count == '0) && empty) active <= 1'b0;
    end
  end
endmodule

// File: rtl/mmc_cmd_stub.sv
module mmc_cmd_stub
  import mmc_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [CMD_IDX_W-1:0] index,
  input  logic                 want_resp,
  input  logic                 want_long,
  input  logic [REG_W-1:0]     arg,
  output logic [3:0][REG_W-1:0] resp,
  output logic [CMD_IDX_W-1:0] resp_idx,
  output logic                 ev_sent,
  output logic                 ev_resp,
  output logic                 ev_timeout
);
  logic no_card;

  assign no_card    = (index == NO_CARD_IDX);
  assign ev_timeout = fire && no_card;
  assign ev_resp    = fire && !no_card && want_resp;
  assign ev_sent    = fire && !no_card && !want_resp;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp     <= '0;
      resp_idx <= '0;
    end else if (ev_resp) begin
      resp_idx <= index;
      resp[0]  <= arg;
      if (want_long) begin
        resp[1] <= ~arg;
        resp[2] <= arg;
        resp[3] <= ~arg & ~REG_W'(1);
      end else begin
        resp[1] <= '0;
        resp[2] <= '0;
        resp[3] <= '0;
      end
    end
  end
endmodule

// File: rtl/mmc_host_regs.sv
module mmc_host_regs
  import mmc_regs_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 16,
  localparam int PTR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic [NUM_IRQ-1:0] irq_out
);
  logic [ADDR_W-1:0] ofs;
  logic              wr_en, rd_en, in_window, in_ident;

  logic [7:0]        supply_q, clkctl_q, dctl_q;
  logic [REG_W-1:0]  arg_q, cmd_q, timer_q;
  logic [LEN_W-1:0]  len_q;
  logic [REG_W-1:0]  mask_q [NUM_IRQ];
  logic [EVT_W-1:0]  evt_q;
  logic              hold_q;
  logic [REG_W-1:0]  rdata_q, rd_val;

  logic [REG_W-1:0]  fifo_head;
  logic [PTR_W:0]    fifo_level;
  logic              fifo_full, fifo_empty, eng_active, eng_done;
  logic [LEN_W-1:0]  byte_cnt;
  logic [LEN_W:0]    word_cnt;
  logic              start, fifo_wr_ok, fifo_rd_ok, cmd_fire;
  logic [3:0][REG_W-1:0] resp;
  logic [CMD_IDX_W-1:0]  resp_idx;
  logic              ev_sent, ev_resp, ev_tmo;
  logic [REG_W-1:0]  live_bits, status;

  assign ofs       = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wr_en     = bus_sel && bus_wr;
  assign rd_en     = bus_sel && !bus_wr;
  assign in_window = (ofs[ADDR_W-1:6] == 6'b000010);
  assign in_ident  = (ofs[ADDR_W-1:5] == 7'b1111111);

  assign start      = wr_en && (ofs == OFS_DCTL) && bus_wdata[DC_RUN];
  assign fifo_wr_ok = wr_en && in_window && (byte_cnt != '0) && !fifo_full;
  assign fifo_rd_ok = rd_en && in_window && !fifo_empty;
  assign cmd_fire   = wr_en && (ofs == OFS_CMD) && bus_wdata[CMD_GO] && !bus_wdata[CMD_HOLD];
  assign word_cnt   = ({1'b0, byte_cnt} + (LEN_W+1)'(3)) >> 2;

  mmc_data_engine #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_eng (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .start_rx      (bus_wdata[DC_RX]),
    .len           (len_q),
    .hold          (hold_q),
    .bus_push      (fifo_wr_ok),
    .bus_push_data (bus_wdata),
    .bus_pop       (fifo_rd_ok),
    .head          (fifo_head),
    .level         (fifo_level),
    .full          (fifo_full),
    .empty         (fifo_empty),
    .count         (byte_cnt),
    .active        (eng_active),
    .done          (eng_done)
  );

  mmc_cmd_stub u_cmd (
    .clk        (clk),
    .rst        (rst),
    .fire       (cmd_fire),
    .index      (bus_wdata[CMD_IDX_W-1:0]),
    .want_resp  (bus_wdata[CMD_RESP]),
    .want_long  (bus_wdata[CMD_LONG]),
    .arg        (arg_q),
    .resp       (resp),
    .resp_idx   (resp_idx),
    .ev_sent    (ev_sent),
    .ev_resp    (ev_resp),
    .ev_timeout (ev_tmo)
  );

  // live FIFO indications, shown only while a transfer is in progress
  always_comb begin
    live_bits = '0;
    if ((byte_cnt != '0) || !fifo_empty) begin
      if (dctl_q[DC_RX]) begin
        live_bits[ST_RX_ACT]   = 1'b1;
        live_bits[ST_RX_HALF]  = (fifo_level >= (PTR_W+1)'(FIFO_DEPTH/2));
        live_bits[ST_RX_FULL]  = fifo_full;
        live_bits[ST_RX_EMPTY] = fifo_empty;
        live_bits[ST_RX_AVAIL] = !fifo_empty;
      end else begin
        live_bits[ST_TX_ACT]   = 1'b1;
        live_bits[ST_TX_HALF]  = (fifo_level <= (PTR_W+1)'(FIFO_DEPTH/2));
        live_bits[ST_TX_FULL]  = fifo_full;
        live_bits[ST_TX_EMPTY] = fifo_empty;
        live_bits[ST_TX_AVAIL] = !fifo_empty;
      end
    end
  end

  assign status = live_bits | REG_W'(evt_q);

  always_comb begin
    rd_val = '0;
    if (in_window) begin
      rd_val = fifo_empty ? '0 : fifo_head;
    end else if (in_ident) begin
      rd_val = REG_W'(ident_byte(ofs[4:2]));
    end else begin
      case (ofs)
        OFS_SUPPLY: rd_val = REG_W'(supply_q);
        OFS_CLKCTL: rd_val = REG_W'(clkctl_q);
        OFS_ARG:    rd_val = arg_q;
        OFS_CMD:    rd_val = cmd_q;
        OFS_RSPIDX: rd_val = REG_W'(resp_idx);
        OFS_RSP0:   rd_val = resp[0];
        OFS_RSP1:   rd_val = resp[1];
        OFS_RSP2:   rd_val = resp[2];
        OFS_RSP3:   rd_val = resp[3];
        OFS_TIMER:  rd_val = timer_q;
        OFS_LEN:    rd_val = REG_W'(len_q);
        OFS_DCTL:   rd_val = REG_W'({dctl_q[7:1], eng_active});
        OFS_DCNT:   rd_val = REG_W'(byte_cnt);
        OFS_STAT:   rd_val = status;
        OFS_MASK0:  rd_val = mask_q[0];
        OFS_MASK1:  rd_val = mask_q[1];
        OFS_WCNT:   rd_val = REG_W'(word_cnt);
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      supply_q <= '0;
      clkctl_q <= '0;
      dctl_q   <= '0;
      arg_q    <= '0;
      cmd_q    <= '0;
      timer_q  <= '0;
      len_q    <= '0;
      rdata_q  <= '0;
      hold_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (ofs)
          OFS_SUPPLY: supply_q <= bus_wdata[7:0];
          OFS_CLKCTL: clkctl_q <= bus_wdata[7:0];
          OFS_ARG:    arg_q    <= bus_wdata;
          OFS_CMD:    cmd_q    <= bus_wdata & ~(REG_W'(1) << CMD_GO);
          OFS_TIMER:  timer_q  <= bus_wdata;
          OFS_LEN:    len_q    <= bus_wdata[LEN_W-1:0];
          OFS_DCTL:   dctl_q   <= bus_wdata[7:0];
          default: ;
        endcase
      end
      if (rd_en) rdata_q <= rd_val;
      if (fifo_rd_ok) hold_q <= 1'b1;
      else if (rd_en && ((ofs == OFS_STAT) || (ofs == OFS_WCNT))) hold_q <= 1'b0;
    end
  end

  // event bits: clear first, new events win
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
    end else begin
      logic [EVT_W-1:0] nxt;
      nxt = evt_q;
      if (wr_en && (ofs == OFS_CLR)) nxt = nxt & ~bus_wdata[EVT_W-1:0];
      if (ev_tmo)   nxt[ST_CMD_TMO]  = 1'b1;
      if (ev_resp)  nxt[ST_RSP_DONE] = 1'b1;
      if (ev_sent)  nxt[ST_CMD_DONE] = 1'b1;
      if (eng_done) begin
        nxt[ST_DAT_END] = 1'b1;
        nxt[ST_BLK_END] = 1'b1;
      end
      evt_q <= nxt;
    end
  end

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
      localparam logic [ADDR_W-1:0] MASK_OFS = (g == 0) ? OFS_MASK0 : OFS_MASK1;
      always_ff @(posedge clk) begin
        if (rst) begin
          mask_q[g]  <= '0;
          irq_out[g] <= 1'b0;
        end else begin
          if (wr_en && (ofs == MASK_OFS)) mask_q[g] <= bus_wdata;
          irq_out[g] <= |(status & mask_q[g]);
        end
      end
    end
  endgenerate

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/mmc_regs_chk.sv
module mmc_regs_chk #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       irq,
  input logic [31:0]      mask0,
  input logic             hold,
  input logic             bus_push,
  input logic [PTR_W:0]   level,
  input logic [LEN_W-1:0] count,
  input logic             start,
  input logic             active,
  input logic             empty
);
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= {seen[0], 1'b1};
    else     seen <= {seen[0], seen[0]};
  end

  // R6: a line whose mask was zero stays low
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (seen[1] && $past(mask0) == '0) |-> !irq[0]);

  // R9: the FIFO never holds more than its depth
  a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= (PTR_W+1)'(DEPTH));

  // R11: while held, only the bus may add words
  a_r11_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    (seen[1] && hold && !bus_push) |=> level <= $past(level));

  // R10: the byte count only falls, except at a start
  a_r10_count_falls: assert property (@(posedge clk) disable iff (rst)
    (seen[1] && !start) |=> count <= $past(count));

  // R8: an exhausted, drained transfer goes idle
  a_r8_goes_idle: assert property (@(posedge clk) disable iff (rst)
    (seen[1] && active && count == '0 && empty && !start) |=> !active);
endmodule

bind mmc_host_regs mmc_regs_chk #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq_out),
  .mask0    (mask_q[0]),
  .hold     (hold_q),
  .bus_push (fifo_wr_ok),
  .level    (fifo_level),
  .count    (byte_cnt),
  .start    (start),
  .active   (eng_active),
  .empty    (fifo_empty)
);

// File: tb/sim_mmc_host_regs.sv
module sim_mmc_host_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_host_regs #(.FIFO_DEPTH(4), .LEN_W(16)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // {offset, write value, read-back value} for R2 widths
  localparam logic [75:0] VEC [8] = '{
    {12'h000, 32'hFFFFFFFF, 32'h000000FF},
    {12'h004, 32'h12345A5A, 32'h0000005A},
    {12'h008, 32'hDEADBEEF, 32'hDEADBEEF},
    {12'h024, 32'h0BADF00D, 32'h0BADF00D},
    {12'h028, 32'hABCD1234, 32'h00001234},
    {12'h02C, 32'h000001FE, 32'h000000FE},
    {12'h03C, 32'hF0F0F000, 32'hF0F0F000},
    {12'h040, 32'h0F0F0F00, 32'h0F0F0F00}
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd_check("R1 supply", 12'h000, 0);
    rd_check("R1 status", 12'h034, 0);
    rd_check("R1 dctl", 12'h02C, 0);
    rd_check("R1 mask1", 12'h040, 0);
    check("R1 irq", {30'd0, irq_out}, 0);

    // R2 table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd_check("R2 width", VEC[i][75:64], VEC[i][31:0]);
    end
    wr(12'h03C, 0);
    wr(12'h040, 0);
    wr(12'h02C, 0);

    // R3 identification bytes
    begin
      logic [7:0] ids [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int k = 0; k < 8; k++) rd_check("R3 ident", 12'hFE0 + 12'(k*4), 32'(ids[k]));
    end

    // R4 undefined offsets
    wr(12'h044, 32'hFFFFFFFF);
    wr(12'h04C, 32'hFFFFFFFF);
    rd_check("R4 read 0x44", 12'h044, 0);
    rd_check("R4 read 0x4C", 12'h04C, 0);
    rd_check("R4 supply kept", 12'h000, 32'hFF);
    rd_check("R4 status kept", 12'h034, 0);

    // R7 commands
    wr(12'h008, 32'h12345678);
    wr(12'h00C, 32'h00000445);
    rd_check("R7 short status", 12'h034, 32'h40);
    rd_check("R7 cmd stored", 12'h00C, 32'h45);
    rd_check("R7 rsp0", 12'h014, 32'h12345678);
    rd_check("R7 rsp1", 12'h018, 0);
    rd_check("R7 rsp idx", 12'h010, 5);
    wr(12'h038, 32'h7FF);
    wr(12'h00C, 32'h000004C7);
    rd_check("R7 long rsp1", 12'h018, 32'hEDCBA987);
    rd_check("R7 long rsp2", 12'h01C, 32'h12345678);
    rd_check("R7 long rsp3", 12'h020, 32'hEDCBA986);
    rd_check("R7 long idx", 12'h010, 7);
    wr(12'h038, 32'h7FF);
    wr(12'h00C, 32'h00000402);
    rd_check("R7 no response", 12'h034, 32'h80);
    wr(12'h038, 32'h7FF);
    wr(12'h00C, 32'h0000047F);
    rd_check("R7 timeout", 12'h034, 32'h04);
    wr(12'h038, 32'h7FF);
    wr(12'h00C, 32'h00000641);
    rd_check("R7 pending nothing", 12'h034, 0);
    rd_check("R7 pending stored", 12'h00C, 32'h241);

    // R8 / R9 / R10 / R11 card-to-host, 22 bytes, depth 4
    wr(12'h028, 22);
    wr(12'h02C, 32'h03);
    idle(8);
    rd_check("R9 rx full", 12'h034, 32'h0022A000);
    wr(12'h038, 32'hFFFFFFFF);
    rd_check("R5 live bits kept", 12'h034, 32'h0022A000);
    rd_check("R10 word count", 12'h048, 2);
    rd_check("R10 byte count", 12'h030, 6);
    rd_check("R8 word0", 12'h080, 32'h03020100);
    idle(5);
    rd_check("R11 held at three", 12'h034, 32'h0020A000);
    idle(5);
    rd_check("R11 refilled", 12'h034, 32'h0022A000);
    rd_check("R11 count after refill", 12'h030, 2);
    rd_check("R8 word1", 12'h0BC, 32'h07060504);
    idle(5);
    rd_check("R11 release value", 12'h048, 1);
    idle(5);
    rd_check("R8 end bits", 12'h034, 32'h0022A500);
    rd_check("R8 word2", 12'h084, 32'h0B0A0908);
    rd_check("R8 word3", 12'h088, 32'h0F0E0D0C);
    rd_check("R8 word4", 12'h08C, 32'h13121110);
    rd_check("R8 partial word", 12'h090, 32'h00001514);
    idle(3);
    rd_check("R9 idle status", 12'h034, 32'h500);
    rd_check("R8 dctl idle", 12'h02C, 32'h02);
    rd_check("R12 empty read", 12'h080, 0);

    // R6 interrupts
    wr(12'h03C, 32'h100);
    wr(12'h040, 32'h4);
    idle(2);
    check("R6 irq0 high", 32'(irq_out[0]), 1);
    check("R6 irq1 low", 32'(irq_out[1]), 0);
    wr(12'h038, 32'h100);
    idle(2);
    check("R6 irq0 cleared", 32'(irq_out[0]), 0);
    rd_check("R5 partial clear", 12'h034, 32'h400);
    wr(12'h040, 32'h400);
    idle(2);
    check("R6 irq1 high", 32'(irq_out[1]), 1);
    wr(12'h038, 32'hFFFFF800);
    rd_check("R5 upper clear ignored", 12'h034, 32'h400);
    wr(12'h038, 32'h400);
    idle(2);
    check("R6 irq1 low again", 32'(irq_out[1]), 0);
    wr(12'h03C, 0);
    wr(12'h040, 0);

    // R13 host-to-card, 8 bytes
    wr(12'h028, 8);
    wr(12'h02C, 32'h01);
    idle(2);
    rd_check("R9 tx empty", 12'h034, 32'h00045000);
    wr(12'h080, 32'hAABBCCDD);
    idle(3);
    rd_check("R13 count after word", 12'h030, 4);
    wr(12'h084, 32'h11223344);
    idle(4);
    rd_check("R13 tx done", 12'h034, 32'h500);
    rd_check("R13 dctl idle", 12'h02C, 0);
    wr(12'h080, 32'h55555555);
    idle(2);
    rd_check("R12 write ignored status", 12'h034, 32'h500);
    rd_check("R12 read after ignored", 12'h080, 0);

    // R1 reset in mid use
    wr(12'h000, 32'h33);
    wr(12'h03C, 32'h100);
    idle(2);
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    rd_check("R1 supply after reset", 12'h000, 0);
    rd_check("R1 mask after reset", 12'h03C, 0);
    rd_check("R1 status after reset", 12'h034, 0);
    check("R1 irq after reset", {30'd0, irq_out}, 0);

    finish_run();
  end
endmodule